// File: doc/BRIEF.md
# Colour Standard Identification Scanner

This block is the control state machine of a multi-standard colour decoder. It works out which colour standard the incoming video uses. While searching it steps a one-hot standard select through four modes. For each mode it reads two identification flags that the analog demodulators produce: a PAL/SECAM flag and an NTSC flag. When the flags confirm the mode it is in, the block stops searching, locks that standard and, after a short settling delay, releases the colour killer.

All decisions are taken on the field-blanking strobe, so the selected standard never switches in the visible part of a field. Three rules shape the search. A positive PAL/SECAM flag seen in SECAM mode is checked in PAL mode first, so PAL wins over SECAM. A 60 Hz field rate rules out SECAM. Loss of the signal is tolerated for a few fields before the search starts again. External forcing inputs let a system controller pin the decoder to one standard.

Top module: `cs_scan_top`

## Requirements
- R1: The standard select is one-hot: bit 0 is PAL, bit 1 is SECAM, bit 2 is NTSC 3.58 and bit 3 is NTSC 4.43. An unidentified search steps PAL, SECAM, NTSC 3.58, NTSC 4.43 and then wraps back to PAL.
- R2: With no identification, the search leaves a mode on the 4th field strobe after entering it. After reset the 4th strobe also counts as the 4th.
- R3: The select, the search status and the colour enable change only on a clock edge where the field strobe is high.
- R4: In SECAM mode at 50 Hz, a positive PAL/SECAM flag first moves the search to PAL. If PAL is not confirmed at the next strobe, the search returns to SECAM and stays there for any number of fields. The next positive PAL/SECAM flag then locks SECAM.
- R5: In SECAM mode at 60 Hz (rate input high), a positive PAL/SECAM flag moves the search straight to NTSC 3.58 at that strobe.
- R6: Each mode is confirmed by its own flags. PAL needs the PAL/SECAM flag. SECAM needs the PAL/SECAM flag at 50 Hz. NTSC 3.58 needs the NTSC flag. NTSC 4.43 needs the NTSC flag with the PAL/SECAM flag low. A confirmed mode locks, and the search status goes low.
- R7: Colour enable rises on the 3rd confirming strobe after the lock strobe. It is low whenever the block is searching.
- R8: While locked, the first non-confirming strobe clears colour enable. The 3rd consecutive non-confirming strobe resumes the search in PAL. A confirming strobe before that keeps the lock, and colour then needs 3 confirming strobes again.
- R9: Hue enable is high only while an NTSC standard is locked.
- R10: At a strobe where any force bit is high, the lowest asserted bit selects its standard and locks it with colour off. While the force bit stays high, loss of signal does not resume the search.
- R11: Synchronous active-high reset selects PAL, searching, with colour and hue off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fld_blank | input | 1 | One-cycle field-blanking strobe |
| rate_60hz | input | 1 | High when the field rate is 60 Hz |
| id_pal_secam | input | 1 | PAL/SECAM identification flag, high = positive |
| id_ntsc | input | 1 | NTSC identification flag, high = positive |
| force_std | input | 4 | Forced standard requests, same bit order as the select |
| std_sel | output | 4 | One-hot standard select |
| scanning | output | 1 | High while searching, low when locked |
| colour_en | output | 1 | Colour killer release |
| hue_en | output | 1 | Hue control enable |

## Verification
Every output is a register loaded only at a strobe edge. The effect of a strobe is therefore due on the clock edge that samples it. The bench drives inputs on falling edges and samples outputs on the next falling edge after that strobe. A behavioural model in the bench counts fields since each mode or lock was entered. It is compared with the outputs at every falling edge, which also shows that nothing moves between strobes. The directed checks for the colour-on, colour-off and hold delays are placed after exactly 3, 1 and 3 strobes, counted from the strobe that caused the lock or loss.

// File: rtl/cs_pkg.sv
package cs_pkg;
   localparam int N_STD = 4;
   localparam int STD_W = 2;
   typedef enum logic [STD_W-1:0] {
      STD_PAL   = 2'd0,
      STD_SECAM = 2'd1,
      STD_N358  = 2'd2,
      STD_N443  = 2'd3
   } std_e;
endpackage

// File: rtl/cs_id_match.sv
module cs_id_match
   import cs_pkg::*;
(
   input  std_e mode,
   input  logic ps_flag,
   input  logic nt_flag,
   input  logic rate60,
   output logic match
);
   always_comb begin
      unique case (mode)
         STD_PAL:   match = ps_flag;
         STD_SECAM: match = ps_flag && !rate60;
         STD_N358:  match = nt_flag;
         default:   match = nt_flag && !ps_flag;
      endcase
   end
endmodule

// File: rtl/cs_force_pick.sv
module cs_force_pick #(
   parameter  int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   generate
      if (N < 2) begin : g_bad_n
         $error("cs_force_pick needs at least two requests");
      end
   endgenerate

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/cs_field_cnt.sv
module cs_field_cnt #(
   parameter  int LIMIT = 4,
   localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic step,
   output logic last
);
   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);
   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("cs_field_cnt LIMIT must be at least one");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr)             cnt_q <= '0;
      else if (step && cnt_q != TOP) cnt_q <= cnt_q + CW'(1);
   end

   assign last = (cnt_q == TOP);
endmodule

// File: rtl/cs_scan_top.sv
module cs_scan_top
   import cs_pkg::*;
#(
   parameter int DWELL_FIELDS     = 4,
   parameter int COLOUR_ON_FIELDS = 3,
   parameter int HOLD_FIELDS      = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fld_blank,
   input  logic             rate_60hz,
   input  logic             id_pal_secam,
   input  logic             id_ntsc,
   input  logic [N_STD-1:0] force_std,
   output logic [N_STD-1:0] std_sel,
   output logic             scanning,
   output logic             colour_en,
   output logic             hue_en
);
   std_e mode_q, mode_n;
   logic scan_q, scan_n;
   logic back_q, back_n;
   logic col_q, col_n;
   logic match, frc_any;
   logic [STD_W-1:0] frc_idx;
   logic dw_clr, dw_step, dw_last;
   logic on_clr, on_step, on_last;
   logic ms_clr, ms_step, ms_last;
   logic go_lock, do_dwell;
   std_e lock_std;
   logic [STD_W-1:0] next_idx;

   generate
      if (DWELL_FIELDS < 1 || COLOUR_ON_FIELDS < 1 || HOLD_FIELDS < 1) begin : g_bad_cfg
         $error("cs_scan_top field counts must be at least one");
      end
   endgenerate

   cs_id_match i_match (
      .mode(mode_q), .ps_flag(id_pal_secam), .nt_flag(id_ntsc),
      .rate60(rate_60hz), .match(match)
   );

   cs_force_pick #(.N(N_STD)) i_force (
      .req(force_std), .any(frc_any), .idx(frc_idx)
   );

   cs_field_cnt #(.LIMIT(DWELL_FIELDS)) i_dwell (
      .clk(clk), .rst(rst), .clr(dw_clr), .step(dw_step), .last(dw_last)
   );
   cs_field_cnt #(.LIMIT(COLOUR_ON_FIELDS)) i_colour_on (
      .clk(clk), .rst(rst), .clr(on_clr), .step(on_step), .last(on_last)
   );
   cs_field_cnt #(.LIMIT(HOLD_FIELDS)) i_hold (
      .clk(clk), .rst(rst), .clr(ms_clr), .step(ms_step), .last(ms_last)
   );

   assign next_idx = mode_q + STD_W'(1);

   always_comb begin
      mode_n   = mode_q;
      scan_n   = scan_q;
      back_n   = back_q;
      col_n    = col_q;
      dw_clr   = 1'b0;
      dw_step  = 1'b0;
      on_clr   = 1'b0;
      on_step  = 1'b0;
      ms_clr   = 1'b0;
      ms_step  = 1'b0;
      go_lock  = 1'b0;
      do_dwell = 1'b0;
      lock_std = mode_q;
      if (fld_blank) begin
         if (frc_any && (scan_q || mode_q != std_e'(frc_idx))) begin
            go_lock  = 1'b1;
            lock_std = std_e'(frc_idx);
         end else if (!scan_q) begin
            if (match) begin
               ms_clr  = 1'b1;
               on_step = 1'b1;
               if (on_last) col_n = 1'b1;
            end else begin
               col_n   = 1'b0;
               on_clr  = 1'b1;
               ms_step = 1'b1;
               if (ms_last && !frc_any) begin
                  scan_n = 1'b1;
                  mode_n = STD_PAL;
                  back_n = 1'b0;
                  dw_clr = 1'b1;
                  ms_clr = 1'b1;
               end
            end
         end else begin
            unique case (mode_q)
               STD_PAL: begin
                  if (match) go_lock = 1'b1;
                  else if (back_q) begin
                     mode_n = STD_SECAM;
                     dw_clr = 1'b1;
                  end else do_dwell = 1'b1;
               end
               STD_SECAM: begin
                  if (id_pal_secam && rate_60hz) begin
                     mode_n = STD_N358;
                     back_n = 1'b0;
                     dw_clr = 1'b1;
                  end else if (id_pal_secam) begin
                     if (back_q) go_lock = 1'b1;
                     else begin
                        mode_n = STD_PAL;
                        back_n = 1'b1;
                        dw_clr = 1'b1;
                     end
                  end else if (!back_q) do_dwell = 1'b1;
               end
               default: begin
                  if (match) go_lock = 1'b1;
                  else do_dwell = 1'b1;
               end
            endcase
            if (do_dwell) begin
               if (dw_last) begin
                  mode_n = std_e'(next_idx);
                  dw_clr = 1'b1;
               end else dw_step = 1'b1;
            end
         end
         if (go_lock) begin
            scan_n = 1'b0;
            mode_n = lock_std;
            back_n = 1'b0;
            col_n  = 1'b0;
            on_clr = 1'b1;
            ms_clr = 1'b1;
            dw_clr = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= STD_PAL;
         scan_q <= 1'b1;
         back_q <= 1'b0;
         col_q  <= 1'b0;
      end else begin
         mode_q <= mode_n;
         scan_q <= scan_n;
         back_q <= back_n;
         col_q  <= col_n;
      end
   end

   for (genvar g = 0; g < N_STD; g++) begin : g_sel
      assign std_sel[g] = (mode_q == std_e'(g));
   end

   assign scanning  = scan_q;
   assign colour_en = col_q;
   assign hue_en    = !scan_q && (mode_q == STD_N358 || mode_q == STD_N443);

   p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      !fld_blank |=> $stable(std_sel) && $stable(scanning) && $stable(colour_en));

   p_no_colour_scan_r7: assert property (@(posedge clk) disable iff (rst)
      scanning |-> !colour_en);

   p_colour_cause_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(colour_en) |-> $past(match) && $past(fld_blank));

   p_colour_drop_r8: assert property (@(posedge clk) disable iff (rst)
      fld_blank && !scanning && !match |=> !colour_en);

   p_lock_r6: assert property (@(posedge clk) disable iff (rst)
      fld_blank && scanning && match && (mode_q != STD_SECAM || back_q) |=> !scanning);

   p_force_r10: assert property (@(posedge clk) disable iff (rst)
      fld_blank && frc_any |=> !scanning && std_sel == (N_STD'(1) << $past(frc_idx)));

   p_reset_r11: assert property (@(posedge clk)
      rst |=> scanning && std_sel == N_STD'(1) && !colour_en && !hue_en);
endmodule

// File: tb/test_cs_scan_top.sv
module test_cs_scan_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fb = 1'b0, r60 = 1'b0, ps = 1'b0, nt = 1'b0;
   logic [3:0] frc = 4'b0;
   logic [3:0] std_sel;
   logic scanning, colour_en, hue_en;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cs_scan_top i_cs_scan_top (
      .clk(clk), .rst(rst), .fld_blank(fb), .rate_60hz(r60),
      .id_pal_secam(ps), .id_ntsc(nt), .force_std(frc),
      .std_sel(std_sel), .scanning(scanning), .colour_en(colour_en), .hue_en(hue_en)
   );

   // behavioural reference: counts of fields since each entry
   int m_mode, m_dw, m_on, m_miss;
   bit m_scan, m_back, m_col;

   task automatic m_enter_lock(int s);
      m_scan = 0; m_mode = s; m_back = 0; m_col = 0; m_on = 0; m_miss = 0; m_dw = 0;
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_scan = 1; m_mode = 0; m_back = 0; m_dw = 0; m_on = 0; m_miss = 0; m_col = 0;
      end else if (fb) begin
         int f;
         bit mt;
         f = -1;
         for (int i = 3; i >= 0; i--) if (frc[i]) f = i;
         case (m_mode)
            0: mt = ps;
            1: mt = ps && !r60;
            2: mt = nt;
            default: mt = nt && !ps;
         endcase
         if (f >= 0 && (m_scan || m_mode != f)) m_enter_lock(f);
         else if (!m_scan) begin
            if (mt) begin
               m_miss = 0; m_on++;
               if (m_on >= 3) m_col = 1;
            end else begin
               m_col = 0; m_on = 0; m_miss++;
               if (m_miss >= 3 && f < 0) begin
                  m_scan = 1; m_mode = 0; m_back = 0; m_dw = 0; m_miss = 0;
               end
            end
         end else if (m_mode == 1) begin
            if (ps && r60) begin m_mode = 2; m_back = 0; m_dw = 0; end
            else if (ps) begin
               if (m_back) m_enter_lock(1);
               else begin m_mode = 0; m_back = 1; m_dw = 0; end
            end else if (!m_back) begin
               m_dw++;
               if (m_dw >= 4) begin m_mode = 2; m_dw = 0; end
            end
         end else if (m_mode == 0 && m_back && !mt) begin
            m_mode = 1; m_dw = 0;
         end else if (mt) m_enter_lock(m_mode);
         else begin
            m_dw++;
            if (m_dw >= 4) begin m_mode = (m_mode + 1) % 4; m_dw = 0; end
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst && !done) begin
         logic [3:0] e_sel;
         bit e_hue;
         e_sel = 4'(1 << m_mode);
         e_hue = !m_scan && m_mode >= 2;
         n_cmp++;
         if (std_sel !== e_sel || scanning !== m_scan || colour_en !== m_col || hue_en !== e_hue) begin
            n_bad++;
            $display("FAIL model R1/R7/R9 sel=%b scan=%b col=%b hue=%b exp sel=%b scan=%b col=%b hue=%b",
                     std_sel, scanning, colour_en, hue_en, e_sel, m_scan, m_col, e_hue);
         end
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fld(bit p, bit n, bit r, logic [3:0] f);
      @(negedge clk);
      ps = p; nt = n; r60 = r; frc = f; fb = 1'b1;
      @(negedge clk);
      fb = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; ps = 0; nt = 0; r60 = 0; frc = 0; fb = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      chk("R11 sel", std_sel, 4'b0001);
      chk("R11 scan", scanning, 1);
      chk("R11 colour", colour_en, 0);
      chk("R11 hue", hue_en, 0);

      // R1 R2: empty search
      repeat (3) fld(0, 0, 0, 0);
      chk("R2 still PAL after 3", std_sel, 4'b0001);
      fld(0, 0, 0, 0);
      chk("R1 R2 SECAM after 4", std_sel, 4'b0010);
      repeat (4) fld(0, 0, 0, 0);
      chk("R1 NTSC3.58", std_sel, 4'b0100);
      repeat (4) fld(0, 0, 0, 0);
      chk("R1 NTSC4.43", std_sel, 4'b1000);
      repeat (4) fld(0, 0, 0, 0);
      chk("R1 wrap to PAL", std_sel, 4'b0001);

      // R3: flag without strobe
      ps = 1;
      repeat (3) @(negedge clk);
      chk("R3 no strobe keeps scan", scanning, 1);
      ps = 0;

      // R6 R7 R9: PAL lock
      fld(1, 0, 0, 0);
      chk("R6 PAL lock", scanning, 0);
      chk("R6 PAL sel", std_sel, 4'b0001);
      repeat (2) fld(1, 0, 0, 0);
      chk("R7 colour not yet", colour_en, 0);
      fld(1, 0, 0, 0);
      chk("R7 colour on", colour_en, 1);
      chk("R9 no hue PAL", hue_en, 0);

      // R8: brief loss then return
      fld(0, 0, 0, 0);
      chk("R8 colour off", colour_en, 0);
      fld(1, 0, 0, 0);
      chk("R8 lock held", scanning, 0);
      chk("R8 colour needs delay", colour_en, 0);
      repeat (3) fld(0, 0, 0, 0);
      chk("R8 resume search", scanning, 1);
      chk("R8 resume PAL", std_sel, 4'b0001);

      // R4: PAL priority
      do_reset();
      repeat (4) fld(0, 0, 0, 0);
      fld(1, 0, 0, 0);
      chk("R4 back to PAL", std_sel, 4'b0001);
      chk("R4 still search", scanning, 1);
      fld(0, 0, 0, 0);
      chk("R4 return SECAM", std_sel, 4'b0010);
      repeat (6) fld(0, 0, 0, 0);
      chk("R4 stays SECAM", std_sel, 4'b0010);
      fld(1, 0, 0, 0);
      chk("R4 SECAM lock", scanning, 0);
      repeat (3) fld(1, 0, 0, 0);
      chk("R7 SECAM colour", colour_en, 1);

      // R5: 60 Hz
      do_reset();
      repeat (4) fld(0, 0, 1, 0);
      fld(1, 0, 1, 0);
      chk("R5 skip to NTSC3.58", std_sel, 4'b0100);
      chk("R5 searching", scanning, 1);
      fld(0, 1, 1, 0);
      chk("R6 NTSC3.58 lock", scanning, 0);
      chk("R9 hue NTSC3.58", hue_en, 1);

      // R6: NTSC 4.43 needs low PAL flag
      do_reset();
      repeat (12) fld(0, 0, 0, 0);
      chk("R1 at NTSC4.43", std_sel, 4'b1000);
      fld(1, 1, 0, 0);
      chk("R6 PAL not NTSC4.43", scanning, 1);
      fld(0, 1, 0, 0);
      chk("R6 NTSC4.43 lock", scanning, 0);
      chk("R9 hue NTSC4.43", hue_en, 1);

      // R10: force
      fld(0, 0, 0, 4'b0110);
      chk("R10 lowest force", std_sel, 4'b0010);
      chk("R10 forced lock", scanning, 0);
      repeat (5) fld(0, 0, 0, 4'b0110);
      chk("R10 no resume", scanning, 0);
      fld(0, 0, 0, 0);
      chk("R10 release resumes", scanning, 1);
      chk("R10 release PAL", std_sel, 4'b0001);
      fld(0, 0, 0, 4'b1000);
      chk("R10 force NTSC4.43", std_sel, 4'b1000);
      chk("R9 forced hue", hue_en, 1);

      repeat (4) @(negedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule